// File: doc/BRIEF.md
# Multi-Depth Indexed Pixel Unpacker

This block sits between framebuffer fetch logic and a video encoder. It takes packed framebuffer words and emits one 24-bit RGB color on every cycle in which the display is active. Each word is loaded in parallel into a window register. Every cycle the pixel index is cut from the lowest bits of that register, and the register then shifts right by the current depth. Depths of 1, 2, 4 and 8 bits per pixel use the same path.

The index always addresses an internal palette of 256 colors. When an index is narrower than the palette address, its upper bits are zero, so low depths use only the first 2, 4 or 16 entries. Monochrome also goes through the palette. After reset, entry 0 is black and entry 1 is white, and software can rewrite both to give a tinted mono display.

A host port writes palette entries. A request signal asks the upstream fetch logic for the next word as soon as the current word is used up. If no word is present when one is needed, the block raises an underflow flag and shows entry 0 until data arrives again. A new depth is taken only when a frame-start pulse arrives.

Top module: `pxl_unpacker`

## Requirements
- R1: After reset, pix_valid and underflow are 0, word_req is 1, palette entry 0 reads 24'h000000 and palette entry 1 reads 24'hFFFFFF.
- R2: With mode_sel = 2'd3 (8 bits per pixel), each 16-bit word gives two pixels, low byte first, and the whole byte is the palette address (byte 8'h93 selects entry 147).
- R3: With mode_sel = 2'd2 (4 bits per pixel), each word gives four pixels, lowest nibble first (byte 8'h93 gives index 3 and then index 9).
- R4: With mode_sel = 2'd1 (2 bits per pixel), each word gives eight pixels, bits [1:0] first and then each higher bit pair in turn.
- R5: With mode_sel = 2'd0 (1 bit per pixel), each word gives sixteen pixels, bit 0 first. A 0 bit shows palette entry 0 and a 1 bit shows palette entry 1, whatever values those entries hold.
- R6: At 1, 2 and 4 bits per pixel, the palette index has zeros above the pixel field. Bits of later pixels never reach the index.
- R7: A host write of pal_wdata to entry pal_waddr takes effect for pixels looked up from the next cycle on. A write to one entry in the same cycle as a lookup of another entry leaves that lookup's color unchanged.
- R8: word_req is 1 exactly when the window holds no unused pixels. A word is taken on a clock edge where word_req, word_valid and active are all 1.
- R9: mode_sel is sampled only on a cycle where frame_start is 1. A change at any other time has no effect on how pixels are unpacked.
- R10: pix_valid and pix_rgb follow an active cycle by exactly one clock (a one-cycle palette read), and pix_valid is 0 one clock after an inactive cycle.
- R11: An active cycle in which a word is needed but word_valid is 0 produces, one clock later, pix_valid = 1, underflow = 1 and the color of palette entry 0. Output returns to normal when a word is supplied.
- R12: frame_start discards any unused pixels of the current word, so word_req is 1 on the next cycle and the next pixel comes from a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start-of-frame pulse; samples mode_sel and flushes the window |
| mode_sel | input | 2 | Depth code: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits per pixel |
| active | input | 1 | Display wants one pixel this cycle |
| word_req | output | 1 | Window is empty and needs a new word |
| word_valid | input | 1 | word_data holds a fetched word |
| word_data | input | WORD_W | Packed framebuffer word |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | IDX_W | Palette entry to write |
| pal_wdata | input | COLOR_W | Color to store |
| pix_valid | output | 1 | pix_rgb holds a pixel |
| pix_rgb | output | COLOR_W | Pixel color |
| underflow | output | 1 | The current pixel was shown without source data |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 24-bit color and an 8-bit palette address. At these values every depth is reachable, from two pixels per word at 8 bits up to sixteen at 1 bit, and a low-depth index can select only the first few palette entries. The bench fills the whole palette with distinct colors, so an index that picks up a stray upper bit shows a wrong color. Words are fed back to back, so the refill at the end of each word, an underflow gap, a flush in the middle of a word and a palette write during streaming are all checked cycle by cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2,
    BPP8 = 2'd3
  } bpp_e;

  // width of one pixel field in bits
  function automatic int unsigned field_bits(bpp_e d);
    return 32'd1 << int'(d);
  endfunction

  // number of pixels packed into a word of ww bits
  function automatic int unsigned pix_per_word(bpp_e d, int unsigned ww);
    return ww >> int'(d);
  endfunction

  // mask selecting one pixel field at the bottom of an index
  function automatic int unsigned field_mask(bpp_e d);
    return (32'd1 << field_bits(d)) - 32'd1;
  endfunction

endpackage

// File: rtl/pxu_depth_ctl.sv
module pxu_depth_ctl
  import pxu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] mode_sel,
  output bpp_e       cur_bpp
);

  always_ff @(posedge clk) begin
    if (!rst_n)           cur_bpp <= BPP1;
    else if (frame_start) cur_bpp <= bpp_e'(mode_sel);
  end

  AST_DEPTH_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_bpp)); // R9

endmodule

// File: rtl/pxu_window.sv
module pxu_window
  import pxu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              active,
  input  bpp_e              cur_bpp,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_req,
  output logic [IDX_W-1:0]  idx_now,
  output logic              pix_fire,
  output logic              uf_fire
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              empty;
  logic              load_evt;
  logic [WORD_W-1:0] src;
  logic [WORD_W-1:0] shifted;
  logic [IDX_W-1:0]  mask;
  logic [CNT_W-1:0]  ppw;

  always_comb begin
    empty    = (left_q == '0);
    word_req = empty;
    pix_fire = active && !frame_start;
    load_evt = pix_fire && empty && word_valid;
    uf_fire  = pix_fire && empty && !word_valid;
    src      = load_evt ? word_data : sh_q;
    shifted  = src >> field_bits(cur_bpp);
    mask     = IDX_W'(field_mask(cur_bpp));
    ppw      = CNT_W'(pix_per_word(cur_bpp, WORD_W));
    idx_now  = uf_fire ? '0 : (IDX_W'(src) & mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (frame_start) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_evt) begin
      sh_q   <= shifted;
      left_q <= ppw - CNT_W'(1);
    end else if (pix_fire && !empty) begin
      sh_q   <= shifted;
      left_q <= left_q - CNT_W'(1);
    end
  end

  AST_REQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && left_q == CNT_W'(1)) |=> word_req); // R8
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    left_q < ppw); // R8
  AST_FRAME_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> word_req); // R12

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [COLOR_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [COLOR_W-1:0] rdata
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [COLOR_W-1:0] mem [ENTRIES];

  // reset leaves a black/white mono palette in entries 0 and 1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++)
        mem[i] <= (i == 1) ? {COLOR_W{1'b1}} : '0;
    end else if (wr_en) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(waddr)] == $past(wdata)); // R7

endmodule

// File: rtl/pxl_unpacker.sv
module pxl_unpacker
  import pxu_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic [1:0]         mode_sel,
  input  logic               active,
  output logic               word_req,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  input  logic               pal_we,
  input  logic [IDX_W-1:0]   pal_waddr,
  input  logic [COLOR_W-1:0] pal_wdata,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_rgb,
  output logic               underflow
);

  bpp_e             cur_bpp;
  logic [IDX_W-1:0] idx_now;
  logic             pix_fire;
  logic             uf_fire;

  pxu_depth_ctl u_depth (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_sel    (mode_sel),
    .cur_bpp     (cur_bpp)
  );

  pxu_window #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .active      (active),
    .cur_bpp     (cur_bpp),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_req    (word_req),
    .idx_now     (idx_now),
    .pix_fire    (pix_fire),
    .uf_fire     (uf_fire)
  );

  pxu_palette #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .raddr (idx_now),
    .rdata (pix_rgb)
  );

  // flags delayed by one cycle to line up with the palette read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      underflow <= 1'b0;
    end else begin
      pix_valid <= pix_fire;
      underflow <= uf_fire;
    end
  end

  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fire |=> pix_valid); // R10
  AST_IDLE_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !pix_valid); // R10
  AST_UF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    uf_fire |=> (underflow && pix_valid)); // R11
  AST_UF_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> pix_valid); // R11

endmodule

// File: tb/sim_pxl_unpacker.sv
module sim_pxl_unpacker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        active = 1'b0;
  logic        word_req;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_waddr = '0;
  logic [23:0] pal_wdata = '0;
  logic        pix_valid;
  logic [23:0] pix_rgb;
  logic        underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] pm [256];
  logic [15:0] wbuf [16];

  always #2 clk = ~clk;

  pxl_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_sel(mode_sel),
    .active(active), .word_req(word_req), .word_valid(word_valid),
    .word_data(word_data), .pal_we(pal_we), .pal_waddr(pal_waddr),
    .pal_wdata(pal_wdata), .pix_valid(pix_valid), .pix_rgb(pix_rgb),
    .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // bench model: pixel pos of word w at depth code d
  function automatic int pix_index(logic [15:0] w, int pos, int d);
    int width = 1;
    for (int j = 0; j < d; j++) width = width * 2;
    return int'((w / (16'd1 << (pos * width))) % (17'd1 << width));
  endfunction

  task automatic new_frame(input logic [1:0] d);
    mode_sel = d;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [23:0] c);
    pal_we = 1'b1; pal_waddr = a; pal_wdata = c;
    @(negedge clk);
    pal_we = 1'b0;
    pm[a] = c;
  endtask

  // streams n words of wbuf back to back at depth code d
  task automatic stream(input int d, input int n, input string req);
    int ppw = 16 >> d;
    int wi = 0;
    bit take;
    for (int k = 0; k < n * ppw; k++) begin
      chk(word_req == ((k % ppw) == 0), "R8", "word_req", word_req, (k % ppw) == 0);
      word_valid = (wi < n);
      word_data = wbuf[wi % 16];
      active = 1'b1;
      take = word_req && word_valid;
      @(posedge clk);
      if (take) wi++;
      @(negedge clk);
      chk(pix_valid === 1'b1, "R10", "pix_valid", pix_valid, 1);
      chk(underflow === 1'b0, req, "underflow", underflow, 0);
      chk(pix_rgb === pm[pix_index(wbuf[k / ppw], k % ppw, d)], req,
          $sformatf("pixel %0d", k), pix_rgb, pm[pix_index(wbuf[k / ppw], k % ppw, d)]);
    end
    active = 1'b0;
    word_valid = 1'b0;
    @(negedge clk);
    chk(pix_valid === 1'b0, "R10", "pix_valid after idle", pix_valid, 0);
  endtask

  task automatic t_reset;
    chk(pix_valid === 1'b0, "R1", "pix_valid", pix_valid, 0);
    chk(underflow === 1'b0, "R1", "underflow", underflow, 0);
    chk(word_req === 1'b1, "R1", "word_req", word_req, 1);
  endtask

  task automatic t_mono_default;
    new_frame(2'd0);
    wbuf[0] = 16'h00F2;
    stream(0, 1, "R1"); // default black/white entries
  endtask

  task automatic t_fill_palette;
    for (int i = 0; i < 256; i++)
      pal_write(8'(i), {8'(i), ~8'(i), 8'(i) ^ 8'h5A});
    pal_write(8'd0, 24'h001000);
    pal_write(8'd1, 24'h00FF00); // green mono
  endtask

  task automatic t_mono_tinted;
    new_frame(2'd0);
    wbuf[0] = 16'hA5C3; wbuf[1] = 16'h8001;
    stream(0, 2, "R5");
  endtask

  task automatic t_8bpp;
    new_frame(2'd3);
    wbuf[0] = 16'h5A93; wbuf[1] = 16'hFF00; wbuf[2] = 16'h0180;
    stream(3, 3, "R2");
  endtask

  task automatic t_4bpp;
    new_frame(2'd2);
    wbuf[0] = 16'h0093; wbuf[1] = 16'hFEDC; wbuf[2] = 16'h7F0F;
    stream(2, 3, "R3/R6");
  endtask

  task automatic t_2bpp;
    new_frame(2'd1);
    wbuf[0] = 16'hFFFC; wbuf[1] = 16'h1B1B;
    stream(1, 2, "R4/R6");
  endtask

  task automatic t_depth_hold;
    mode_sel = 2'd3; // no frame_start: must stay at 2 bits per pixel
    wbuf[0] = 16'hE4E4;
    stream(1, 1, "R9");
  endtask

  task automatic t_pal_collision;
    new_frame(2'd3);
    active = 1'b1; word_valid = 1'b1; word_data = 16'h2010;
    pal_we = 1'b1; pal_waddr = 8'h20; pal_wdata = 24'hABCDEF;
    @(negedge clk);
    pal_we = 1'b0; word_valid = 1'b0;
    chk(pix_rgb === pm[8'h10], "R7", "other-entry lookup", pix_rgb, pm[8'h10]);
    pm[8'h20] = 24'hABCDEF;
    @(negedge clk);
    chk(pix_rgb === 24'hABCDEF, "R7", "written entry", pix_rgb, 24'hABCDEF);
    active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_underflow;
    new_frame(2'd3);
    active = 1'b1; word_valid = 1'b1; word_data = 16'h0201;
    @(negedge clk);
    word_valid = 1'b0;
    chk(pix_rgb === pm[1], "R11", "before gap", pix_rgb, pm[1]);
    @(negedge clk);
    chk(pix_rgb === pm[2], "R11", "before gap 2", pix_rgb, pm[2]);
    @(negedge clk);
    chk(underflow === 1'b1, "R11", "underflow", underflow, 1);
    chk(pix_valid === 1'b1, "R11", "pix_valid in gap", pix_valid, 1);
    chk(pix_rgb === pm[0], "R11", "gap color", pix_rgb, pm[0]);
    chk(word_req === 1'b1, "R8", "req in gap", word_req, 1);
    word_valid = 1'b1; word_data = 16'h0403;
    @(negedge clk);
    word_valid = 1'b0;
    chk(underflow === 1'b0, "R11", "resume flag", underflow, 0);
    chk(pix_rgb === pm[3], "R11", "resume color", pix_rgb, pm[3]);
    @(negedge clk);
    chk(pix_rgb === pm[4], "R11", "resume color 2", pix_rgb, pm[4]);
    active = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_flush;
    new_frame(2'd2);
    active = 1'b1; word_valid = 1'b1; word_data = 16'h4321;
    @(negedge clk);
    chk(pix_rgb === pm[1], "R12", "first nibble", pix_rgb, pm[1]);
    active = 1'b0; word_valid = 1'b0;
    frame_start = 1'b1; mode_sel = 2'd2;
    @(negedge clk);
    frame_start = 1'b0;
    chk(word_req === 1'b1, "R12", "req after flush", word_req, 1);
    active = 1'b1; word_valid = 1'b1; word_data = 16'h8765;
    @(negedge clk);
    chk(pix_rgb === pm[5], "R12", "new word first", pix_rgb, pm[5]);
    active = 1'b0; word_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pm[i] = (i == 1) ? 24'hFFFFFF : 24'h000000;
    for (int i = 0; i < 16; i++) wbuf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mono_default();
    t_fill_palette();
    t_mono_tinted();
    t_8bpp();
    t_4bpp();
    t_2bpp();
    t_depth_hold();
    t_pal_collision();
    t_underflow();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule